// File: doc/BRIEF.md
# SMBus Block-Write Configuration Slave

This block is a write-only SMBus target that loads a small bank of seven 8-bit configuration registers. It runs from a fast system clock and oversamples the bus. The SCL and SDA pins are seen as plain inputs, and the only drive is an enable that pulls SDA low. Each line passes through a synchronizer and a short majority-free glitch filter. A separate stage then finds start conditions, stop conditions and clock edges.

A transfer has a fixed layout. First comes the address byte with the write bit, then a command byte that must be zero, then a byte count of 1 to 32. The data bytes follow and fill the registers from index 0 upward. Fields marked read-only keep their values. Two strap inputs are captured once after reset and merged into their register bits. The whole bank is presented as a flat parallel vector, and downstream clock-generation logic decodes it.

Top module: `smbus_cfg_slave`

## Requirements
- R1: Only the address byte 0xD2 (7-bit address 0x69, write bit 0) is acknowledged. Any other address, 0xD3 included, is not acknowledged, and the rest of that transaction changes no register.
- R2: The byte after the address must be 0x00. Any other value is not acknowledged, and the slave ignores the bus until the next start.
- R3: The third byte is a count of data bytes. A value from 1 to 32 is acknowledged. A value of 0 or above 32 is not acknowledged, and the transaction is ignored.
- R4: Every byte is received MSB first. Data bytes are written to register 0, then 1, and so on upward. Register i appears on `cfg_o[8*i+7:8*i]`.
- R5: The master may send a stop after any whole data byte. Registers already written keep their new values, and the registers after them keep their old values.
- R6: After reset the registers read as follows: register 0 = 0x08 plus the strap bits, register 1 = 0xC7, register 2 = 0x7F, register 3 = 0x47 plus the strap bit, register 4 = 0x1F, register 5 = 0x00, register 6 = 0x08. In register 0, bit 7 enables spreading, bit 5 selects the 48 MHz (1) or 66 MHz (0) shared output, and bit 3 is the software stop for the slot clocks.
- R7: Writes change only these bits: mask 0xA8 in register 0, 0xFF in register 1, 0x7F in register 2, 0x47 in register 3, 0x3F in registers 4 and 5, and none in register 6.
- R8: `strap_sel_i` appears in register 0 bits 2:1 and `strap_mult_i` in register 3 bit 7. Both are captured on the first clock after reset, and later changes on those pins have no effect.
- R9: Data bytes within the count that go beyond register 6 are acknowledged and discarded. Bytes beyond the count are not acknowledged.
- R10: An acknowledge pulls SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth. SDA is released while data bits are being received and after a stop.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN clocks is rejected. It adds no bit and creates no start or stop.
- R12: A repeated start in the middle of a transaction restarts the address phase, and data again lands from register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as received |
| sda_i | input | 1 | SDA line level as received |
| sda_pull_o | output | 1 | High enables the SDA pull-down (acknowledge) |
| strap_sel_i | input | 2 | Frequency-select straps reflected in register 0 |
| strap_mult_i | input | 1 | Current-multiplier strap reflected in register 3 |
| cfg_o | output | 56 | Register bank, register i at bits 8i+7:8i |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a three-sample glitch filter, a count limit of 32 and address 0x69. It drives SCL with a half-period of 16 system clocks. With these values a full 32-byte count fits inside the run, so the discard of bytes past register 6 and both limits of the count window can be reached. A one-clock spike on either line sits well below the filter length, so glitch rejection is checked against a real margin. The bench also uses repeated starts and early stops to reach the index restart and partial-write cases.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

    localparam int CFG_REGS  = 7;
    localparam int STRAP_REG = 0;
    localparam int MULT_REG  = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // Power-on value of each register, strap bits excluded
    function automatic logic [7:0] def_val(input int unsigned i);
        case (i)
            0:       def_val = 8'h08;
            1:       def_val = 8'hC7;
            2:       def_val = 8'h7F;
            3:       def_val = 8'h47;
            4:       def_val = 8'h1F;
            5:       def_val = 8'h00;
            6:       def_val = 8'h08;
            default: def_val = 8'h00;
        endcase
    endfunction

    // Bits that a block write may change
    function automatic logic [7:0] wr_mask(input int unsigned i);
        case (i)
            0:       wr_mask = 8'hA8;
            1:       wr_mask = 8'hFF;
            2:       wr_mask = 8'h7F;
            3:       wr_mask = 8'h47;
            4:       wr_mask = 8'h3F;
            5:       wr_mask = 8'h3F;
            default: wr_mask = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbus_line_filter.sv
module smbus_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILT_LEN-1:0]    hist;
        logic                   level;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], line_i};
        d.hist = {q.hist[FILT_LEN-2:0], q.sync[SYNC_STAGES-1]};
        if (&q.hist) begin
            d.level = 1'b1;
        end else if (~|q.hist) begin
            d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.level;

endmodule

// File: rtl/smbus_bus_events.sv
module smbus_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    // SDA moving while SCL stays high marks a bus condition
    assign start_o = q.scl & scl_i & q.sda & ~sda_i;
    assign stop_o  = q.scl & scl_i & ~q.sda & sda_i;
    assign rise_o  = ~q.scl & scl_i;
    assign fall_o  = q.scl & ~scl_i;

endmodule

// File: rtl/smbus_cfg_bank.sv
module smbus_cfg_bank
    import smbus_cfg_pkg::*;
#(
    parameter int NREG = CFG_REGS,
    parameter int IDXW = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDXW-1:0]   wr_idx_i,
    input  logic [7:0]        wr_data_i,
    input  logic [1:0]        strap_sel_i,
    input  logic              strap_mult_i,
    output logic [NREG*8-1:0] cfg_o,
    output logic              strap_ok_o
);

    typedef struct packed {
        logic [NREG-1:0][7:0] store;
        logic [1:0]           strap_sel;
        logic                 strap_mult;
        logic                 strap_ok;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (!q.strap_ok) begin
            d.strap_sel  = strap_sel_i;
            d.strap_mult = strap_mult_i;
            d.strap_ok   = 1'b1;
        end
        if (wr_en_i) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_idx_i == IDXW'(i)) begin
                    d.store[i] = (q.store[i] & ~wr_mask(i)) | (wr_data_i & wr_mask(i));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                q.store[i] <= def_val(i);
            end
            q.strap_sel  <= '0;
            q.strap_mult <= 1'b0;
            q.strap_ok   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        localparam logic [7:0] MASK  = wr_mask(g);
        localparam logic [7:0] FIXED = def_val(g);
        logic [7:0] strap_bits;

        always_comb begin
            strap_bits = '0;
            if (g == STRAP_REG) strap_bits[2:1] = q.strap_sel;
            if (g == MULT_REG)  strap_bits[7]   = q.strap_mult;
        end

        assign cfg_o[8*g +: 8] = (q.store[g] & MASK) | (FIXED & ~MASK) | strap_bits;
    end

    assign strap_ok_o = q.strap_ok;

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
    import smbus_cfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter logic [7:0] CMD_CODE    = 8'h00,
    parameter int         MAX_COUNT   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    input  logic [1:0]            strap_sel_i,
    input  logic                  strap_mult_i,
    output logic [CFG_REGS*8-1:0] cfg_o
);

    localparam int NREG = CFG_REGS;
    localparam int IDXW = $clog2(NREG + 1);
    localparam int CNTW = $clog2(MAX_COUNT + 1);

    logic scl_f, sda_f;
    logic start_evt, stop_evt, rise_evt, fall_evt;
    logic strap_ok;

    smbus_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    smbus_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    smbus_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
        .start_o(start_evt), .stop_o(stop_evt), .rise_o(rise_evt), .fall_o(fall_evt)
    );

    typedef struct packed {
        phase_e          phase;
        phase_e          after_ack;
        logic [7:0]      shreg;
        logic [3:0]      bits;
        logic            in_ack;
        logic            pull;
        logic [CNTW-1:0] left;
        logic [IDXW-1:0] idx;
        logic            wr_en;
        logic [IDXW-1:0] wr_idx;
        logic [7:0]      wr_data;
    } proto_t;

    proto_t q, d;
    logic   ack_ok;
    phase_e nxt;
    logic [7:0] rx;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        ack_ok  = 1'b0;
        nxt     = PH_SKIP;
        rx      = q.shreg;
        if (start_evt) begin
            d.phase  = PH_ADDR;
            d.bits   = '0;
            d.in_ack = 1'b0;
            d.pull   = 1'b0;
        end else if (stop_evt) begin
            d.phase  = PH_IDLE;
            d.bits   = '0;
            d.in_ack = 1'b0;
            d.pull   = 1'b0;
        end else if (q.phase != PH_IDLE && q.phase != PH_SKIP) begin
            if (rise_evt && !q.in_ack && q.bits < 4'd8) begin
                d.shreg = {q.shreg[6:0], sda_f};
                d.bits  = q.bits + 4'd1;
            end else if (fall_evt) begin
                if (q.in_ack) begin
                    // end of the ninth pulse: release and move on
                    d.in_ack = 1'b0;
                    d.pull   = 1'b0;
                    d.bits   = '0;
                    d.phase  = q.after_ack;
                end else if (q.bits == 4'd8) begin
                    case (q.phase)
                        PH_ADDR: begin
                            if (rx == {SLAVE_ADDR, 1'b0}) begin
                                ack_ok = 1'b1;
                                nxt    = PH_CMD;
                            end
                        end
                        PH_CMD: begin
                            if (rx == CMD_CODE) begin
                                ack_ok = 1'b1;
                                nxt    = PH_COUNT;
                            end
                        end
                        PH_COUNT: begin
                            if (rx != 8'd0 && rx <= 8'(MAX_COUNT)) begin
                                ack_ok = 1'b1;
                                nxt    = PH_DATA;
                                d.left = rx[CNTW-1:0];
                                d.idx  = '0;
                            end
                        end
                        PH_DATA: begin
                            if (q.left != '0) begin
                                ack_ok = 1'b1;
                                nxt    = PH_DATA;
                                d.left = q.left - CNTW'(1);
                                if (q.idx < IDXW'(NREG)) begin
                                    d.wr_en   = 1'b1;
                                    d.wr_idx  = q.idx;
                                    d.wr_data = rx;
                                    d.idx     = q.idx + IDXW'(1);
                                end
                            end
                        end
                        default: ;
                    endcase
                    if (ack_ok) begin
                        d.in_ack    = 1'b1;
                        d.pull      = 1'b1;
                        d.after_ack = nxt;
                    end else begin
                        d.phase = PH_SKIP;
                        d.bits  = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    smbus_cfg_bank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(q.wr_en), .wr_idx_i(q.wr_idx), .wr_data_i(q.wr_data),
        .strap_sel_i(strap_sel_i), .strap_mult_i(strap_mult_i),
        .cfg_o(cfg_o), .strap_ok_o(strap_ok)
    );

    assign sda_pull_o = q.pull;

endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk
    import smbus_cfg_pkg::*;
#(
    parameter int NREG = CFG_REGS,
    parameter int IDXW = $clog2(NREG + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull_o,
    input logic              scl_f,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              wr_en,
    input logic [IDXW-1:0]   wr_idx,
    input phase_e            phase,
    input logic              strap_ok,
    input logic [NREG*8-1:0] cfg_o
);

    // R7: the identification register never moves
    assert_vendor_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[8*(NREG-1) +: 8] == 8'h08);

    // R5: without a write strobe the bank holds its contents
    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_ok && !wr_en) |=> $stable(cfg_o));

    // R4: writes originate only in the data phase
    assert_write_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(phase) == PH_DATA);

    // R9: no write index past the last register
    assert_index_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IDXW'(NREG));

    // R10: a stop releases the data line
    assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o);

    // R10: the pull-down starts only while SCL is low
    assert_ack_while_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f);

    // R12: a (repeated) start returns to the address phase with SDA free
    assert_start_restarts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (phase == PH_ADDR && !sda_pull_o));

endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .scl_f(scl_f),
    .start_evt(start_evt), .stop_evt(stop_evt), .wr_en(q.wr_en),
    .wr_idx(q.wr_idx), .phase(q.phase), .strap_ok(strap_ok), .cfg_o(cfg_o)
);

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;
    localparam int NREG       = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [1:0] strap_sel = 2'b10;
    logic strap_mult = 1'b1;
    logic [NREG*8-1:0] cfg;

    int total = 0;
    int failed = 0;
    bit done = 0;

    logic [7:0] exp_reg [NREG];
    bit    exp_q [$];
    string tag_q [$];
    logic  ack_strobe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    smbus_cfg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_sel_i(strap_sel), .strap_mult_i(strap_mult),
        .cfg_o(cfg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Writable bits per register, from the requirements
    function automatic logic [7:0] bench_mask(input int i);
        case (i)
            0: return 8'hA8;
            1: return 8'hFF;
            2: return 8'h7F;
            3: return 8'h47;
            4: return 8'h3F;
            5: return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic apply(input int i, input logic [7:0] v);
        exp_reg[i] = (exp_reg[i] & ~bench_mask(i)) | (v & bench_mask(i));
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++) begin
            check(cfg[8*i +: 8] === exp_reg[i], req, $sformatf("reg%0d", i), cfg[8*i +: 8], exp_reg[i]);
        end
    endtask

    // Monitor: compares each acknowledge slot against the scoreboard queue
    always @(posedge ack_strobe) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(sda_pull === e, t, "ack", sda_pull, e);
    end

    task automatic start_cond();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0;
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
        check(sda_pull === 1'b0, "R10", "release after stop", sda_pull, 0);
    endtask

    // Driver: sends one byte and queues the expected acknowledge
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                             input bit glitch = 0);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                wait_clk(HALF/2);
                scl_m = 1'b1; wait_clk(1); scl_m = 1'b0;
                wait_clk(HALF - HALF/2 - 1);
            end else begin
                wait_clk(HALF);
            end
            scl_m = 1'b1;
            wait_clk(HALF/2);
            if (i == 7) check(sda_pull === 1'b0, "R10", "released during data", sda_pull, 0);
            if (glitch && i == 2) begin
                sda_m = ~b[i]; wait_clk(1); sda_m = b[i];
                wait_clk(HALF - HALF/2 - 1);
            end else begin
                wait_clk(HALF - HALF/2);
            end
            scl_m = 1'b0;
        end
        sda_m = 1'b1;
        exp_q.push_back(exp_ack);
        tag_q.push_back(req);
        wait_clk(HALF);
        scl_m = 1'b1;
        wait_clk(HALF/2);
        ack_strobe = 1'b1; wait_clk(1); ack_strobe = 1'b0;
        wait_clk(HALF - HALF/2 - 1);
        scl_m = 1'b0;
    endtask

    task automatic xfer(input int cnt, input int nsend, input logic [7:0] base,
                        input logic [7:0] step, input string req);
        logic [7:0] v;
        start_cond();
        send_byte(8'hD2, 1, "R1");
        send_byte(8'h00, 1, "R2");
        send_byte(8'(cnt), 1, "R3");
        for (int k = 0; k < nsend; k++) begin
            v = base + 8'(k) * step;
            send_byte(v, k < cnt, req);
            if (k < cnt && k < NREG) apply(k, v);
        end
        stop_cond();
        wait_clk(8);
        check_regs(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "timeout", 0, 1);
        finish_run();
    end

    initial begin
        exp_reg[0] = 8'h0C; exp_reg[1] = 8'hC7; exp_reg[2] = 8'h7F; exp_reg[3] = 8'hC7;
        exp_reg[4] = 8'h1F; exp_reg[5] = 8'h00; exp_reg[6] = 8'h08;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(20);
        // R6 and R8: defaults with straps merged
        check_regs("R6");
        check(cfg[2:1] === 2'b10, "R8", "strap sel", cfg[2:1], 2'b10);
        check(sda_pull === 1'b0, "R10", "idle release", sda_pull, 0);
        // R8: later strap changes ignored
        strap_sel = 2'b01; strap_mult = 1'b0;
        wait_clk(20);
        check_regs("R8");

        // R7: all-ones write touches only writable bits
        xfer(7, 7, 8'hFF, 8'h00, "R7");
        // R4: ordered distinct pattern
        xfer(7, 7, 8'h11, 8'h11, "R4");

        // R1: foreign address and read bit
        start_cond();
        send_byte(8'hD4, 0, "R1"); send_byte(8'h00, 0, "R1");
        send_byte(8'h01, 0, "R1"); send_byte(8'h55, 0, "R1");
        stop_cond(); check_regs("R1");
        start_cond();
        send_byte(8'hD3, 0, "R1"); send_byte(8'h00, 0, "R1");
        stop_cond(); check_regs("R1");

        // R2: bad command code
        start_cond();
        send_byte(8'hD2, 1, "R2"); send_byte(8'h05, 0, "R2");
        send_byte(8'h01, 0, "R2"); send_byte(8'hAA, 0, "R2");
        stop_cond(); check_regs("R2");

        // R3: counts of 0 and 33
        start_cond();
        send_byte(8'hD2, 1, "R3"); send_byte(8'h00, 1, "R3");
        send_byte(8'h00, 0, "R3"); send_byte(8'hAA, 0, "R3");
        stop_cond(); check_regs("R3");
        start_cond();
        send_byte(8'hD2, 1, "R3"); send_byte(8'h00, 1, "R3");
        send_byte(8'd33, 0, "R3"); send_byte(8'hAA, 0, "R3");
        stop_cond(); check_regs("R3");

        // R9: count 32, bytes past register 6 acknowledged and dropped
        xfer(32, 32, 8'h5A, 8'h03, "R9");
        // R9: byte beyond the count refused
        xfer(2, 3, 8'hC3, 8'h21, "R9");
        // R5: early stop keeps partial write
        xfer(5, 2, 8'h00, 8'h01, "R5");

        // R12: repeated start restarts from register 0
        start_cond();
        send_byte(8'hD2, 1, "R12"); send_byte(8'h00, 1, "R12");
        send_byte(8'h05, 1, "R12"); send_byte(8'h3C, 1, "R12");
        apply(0, 8'h3C);
        start_cond();
        send_byte(8'hD2, 1, "R12"); send_byte(8'h00, 1, "R12");
        send_byte(8'h01, 1, "R12"); send_byte(8'h81, 1, "R12");
        apply(0, 8'h81);
        stop_cond(); wait_clk(8); check_regs("R12");

        // R11: one-clock spikes on SCL and SDA rejected
        start_cond();
        send_byte(8'hD2, 1, "R11"); send_byte(8'h00, 1, "R11");
        send_byte(8'h02, 1, "R11");
        send_byte(8'h96, 1, "R11", 1); apply(0, 8'h96);
        send_byte(8'h69, 1, "R11", 1); apply(1, 8'h69);
        stop_cond(); wait_clk(8); check_regs("R11");

        wait_clk(10);
        finish_run();
    end

endmodule